// File: doc/BRIEF.md
# Branch Target Cache Predictor

This block sits in the fetch stage and predicts branches. Each fetch lookup is checked against a small set-associative cache of branch targets. The lookup also reads a table of two-bit saturating history counters. One cycle later the block reports three things: whether the address hit, the cached target, and a taken/not-taken guess. When the mode input turns dynamic prediction off, or the target cache misses, the guess comes from the sign of the branch displacement instead. Backward branches are guessed taken and forward ones not-taken.

Resolved branches come back through an update port. Every update trains the history counter that the branch address selects. A taken update also writes the target cache: it refreshes a matching entry, or else fills a way of the set. The fill takes the lowest invalid way if there is one. Otherwise it takes the way chosen by a three-bit tree pseudo-LRU kept per set. A one-bit flag marks a prediction that is still waiting for resolution, so that later stages can hold back dependent work.

Top module: `bpred_top`

## Requirements
- R1: After synchronous reset, pred_valid, pred_hit, pred_taken and pred_pending are 0, every cache entry is invalid, and every history counter is 01 (weakly not-taken).
- R2: Each lookup gives exactly one cycle of pred_valid=1, at the clock edge after lk_valid is sampled. With no lookup, pred_valid is 0.
- R3: A lookup hits when some valid way of set lk_pc[7:4] holds tag lk_pc[31:8]. pred_target then shows that way's target. On a miss, pred_hit and pred_target are 0.
- R4: When dyn_en=1 and the lookup hits, pred_taken is bit 1 of the history counter at index lk_pc[10:2].
- R5: When dyn_en=0, or the lookup misses, pred_taken equals lk_disp_neg (1 = backward displacement).
- R6: Every update moves the counter at upd_pc[10:2] one step toward 11 (taken) or 00 (not-taken), and it saturates at both ends.
- R7: A taken update that hits overwrites that way's target. A taken update that misses fills the lowest-numbered invalid way, or the pseudo-LRU victim when the set is full. A not-taken update leaves the cache unchanged.
- R8: Per-set pseudo-LRU bits {b2,b1,b0}: when b0=0 the victim is way b1 (way 0 or 1), otherwise it is way 2+b2. Writing a way points the bits away from it: way0 sets b0=1,b1=1; way1 sets b0=1,b1=0; way2 sets b0=0,b2=1; way3 sets b0=0,b2=0.
- R9: An update in the same cycle as a lookup is not visible to that lookup. It takes effect from the next lookup onward.
- R10: pred_pending becomes 1 after a lookup and 0 after an update that has no lookup in the same cycle. A lookup in the same cycle as an update wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_pc | input | 32 | Fetch address to look up |
| lk_disp_neg | input | 1 | Sign bit of the branch displacement |
| dyn_en | input | 1 | 1 selects dynamic prediction, 0 static |
| upd_valid | input | 1 | Resolved-branch update |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome |
| upd_target | input | 32 | Resolved target |
| pred_valid | output | 1 | Prediction result valid |
| pred_hit | output | 1 | Target cache hit |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | 32 | Predicted target (0 on a miss) |
| pred_pending | output | 1 | A prediction awaits resolution |

## Verification
One address is trained with a twelve-step sequence of taken and not-taken outcomes. A lookup after every step separates correct saturation from a counter that wraps or moves by the wrong amount. Static mode is run at both displacement signs, on a cold miss and on a trained hit, to show that the mode input and a miss each force the static rule. One set is filled past its capacity. The eviction order is then read back through which addresses still hit, which separates invalid-first filling from the pseudo-LRU choice. A lookup issued in the same cycle as a taken update to the same address shows that the update is not seen until the following lookup.

// File: rtl/bpred_pkg.sv
package bpred_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_INIT = 2'b01;

  // saturating two-bit history step
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t n;
    n = c;
    if (taken && c != 2'b11) n = c + 2'b01;
    else if (!taken && c != 2'b00) n = c - 2'b01;
    return n;
  endfunction

  // tree pseudo-LRU victim for four ways, bits {b2,b1,b0}
  function automatic logic [1:0] plru_victim(input logic [2:0] b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

  function automatic logic [2:0] plru_touch(input logic [2:0] b, input logic [1:0] w);
    logic [2:0] n;
    n = b;
    case (w)
      2'd0: begin n[0] = 1'b1; n[1] = 1'b1; end
      2'd1: begin n[0] = 1'b1; n[1] = 1'b0; end
      2'd2: begin n[0] = 1'b0; n[2] = 1'b1; end
      default: begin n[0] = 1'b0; n[2] = 1'b0; end
    endcase
    return n;
  endfunction
endpackage

// File: rtl/bpred_hist.sv
module bpred_hist import bpred_pkg::*; #(
  parameter int ENTRIES = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(ENTRIES)-1:0] rd_idx,
  output ctr_t                       rd_ctr,
  input  logic                       wr_en,
  input  logic [$clog2(ENTRIES)-1:0] wr_idx,
  input  logic                       wr_taken
);
  ctr_t tbl_q [ENTRIES];

  assign rd_ctr = tbl_q[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= CTR_INIT;
    end else if (wr_en) begin
      tbl_q[wr_idx] <= ctr_step(tbl_q[wr_idx], wr_taken);
    end
  end

  // R6: saturation at the taken end
  assert_sat_high_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_taken && tbl_q[wr_idx] == 2'b11) |=> tbl_q[$past(wr_idx)] == 2'b11);
  // R6: saturation at the not-taken end
  assert_sat_low_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_taken && tbl_q[wr_idx] == 2'b00) |=> tbl_q[$past(wr_idx)] == 2'b00);
endmodule

// File: rtl/bpred_btc.sv
module bpred_btc import bpred_pkg::*; #(
  parameter int SETS  = 16,
  parameter int TAG_W = 24,
  parameter int TGT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(SETS)-1:0] rd_set,
  input  logic [TAG_W-1:0]        rd_tag,
  output logic                    rd_hit,
  output logic [TGT_W-1:0]        rd_tgt,
  input  logic                    wr_en,
  input  logic [$clog2(SETS)-1:0] wr_set,
  input  logic [TAG_W-1:0]        wr_tag,
  input  logic [TGT_W-1:0]        wr_tgt
);
  localparam int WAYS = 4;  // fixed by the three-bit tree replacement

  logic [WAYS-1:0]  vld_q [SETS];
  logic [2:0]       lru_q [SETS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [TGT_W-1:0] tgt_q [SETS][WAYS];

  logic [WAYS-1:0] rd_hv, wr_hv;
  logic [1:0]      hit_way, free_way, wsel;
  logic            free_any;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign rd_hv[w] = vld_q[rd_set][w] && (tag_q[rd_set][w] == rd_tag);
    assign wr_hv[w] = vld_q[wr_set][w] && (tag_q[wr_set][w] == wr_tag);
  end

  always_comb begin
    rd_tgt = '0;
    for (int w = 0; w < WAYS; w++) if (rd_hv[w]) rd_tgt = tgt_q[rd_set][w];
    rd_hit = |rd_hv;
  end

  always_comb begin
    hit_way  = '0;
    free_way = '0;
    for (int w = 0; w < WAYS; w++) if (wr_hv[w]) hit_way = 2'(w);
    for (int w = WAYS - 1; w >= 0; w--) if (!vld_q[wr_set][w]) free_way = 2'(w);
    free_any = ~&vld_q[wr_set];
    if (|wr_hv)        wsel = hit_way;
    else if (free_any) wsel = free_way;
    else               wsel = plru_victim(lru_q[wr_set]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        lru_q[s] <= '0;
      end
    end else if (wr_en) begin
      vld_q[wr_set][wsel] <= 1'b1;
      lru_q[wr_set]       <= plru_touch(lru_q[wr_set], wsel);
    end
  end

  // payload arrays carry no reset so they can map onto RAM
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_set][wsel] <= wr_tag;
      tgt_q[wr_set][wsel] <= wr_tgt;
    end
  end

  // R3: a tag lives in at most one way of a set
  assert_single_hit_R3: assert property (@(posedge clk) disable iff (rst) $onehot0(rd_hv));
  // R7: a miss into a set with room adds exactly one valid way
  assert_fill_free_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(|wr_hv) && free_any) |=>
      $countones(vld_q[$past(wr_set)]) == $countones($past(vld_q[wr_set])) + 1);
  // R8: the way just written is never the next victim of its set
  assert_plru_away_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> plru_victim(lru_q[$past(wr_set)]) != $past(wsel));
endmodule

// File: rtl/bpred_top.sv
module bpred_top import bpred_pkg::*; #(
  parameter int ADDR_W  = 32,
  parameter int SETS    = 16,
  parameter int HIST_N  = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_pc,
  input  logic              lk_disp_neg,
  input  logic              dyn_en,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  output logic              pred_valid,
  output logic              pred_hit,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  output logic              pred_pending
);
  localparam int SET_LO = 4;
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_LO = SET_LO + SET_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam int HIX_LO = 2;
  localparam int HIX_W  = $clog2(HIST_N);

  logic              c_hit;
  logic [ADDR_W-1:0] c_tgt;
  ctr_t              h_ctr;

  bpred_btc #(.SETS(SETS), .TAG_W(TAG_W), .TGT_W(ADDR_W)) u_btc (
    .clk    (clk),
    .rst    (rst),
    .rd_set (lk_pc[SET_LO +: SET_W]),
    .rd_tag (lk_pc[ADDR_W-1:TAG_LO]),
    .rd_hit (c_hit),
    .rd_tgt (c_tgt),
    .wr_en  (upd_valid && upd_taken),
    .wr_set (upd_pc[SET_LO +: SET_W]),
    .wr_tag (upd_pc[ADDR_W-1:TAG_LO]),
    .wr_tgt (upd_target)
  );

  bpred_hist #(.ENTRIES(HIST_N)) u_hist (
    .clk      (clk),
    .rst      (rst),
    .rd_idx   (lk_pc[HIX_LO +: HIX_W]),
    .rd_ctr   (h_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_pc[HIX_LO +: HIX_W]),
    .wr_taken (upd_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid   <= 1'b0;
      pred_hit     <= 1'b0;
      pred_taken   <= 1'b0;
      pred_target  <= '0;
      pred_pending <= 1'b0;
    end else begin
      pred_valid <= lk_valid;
      if (lk_valid) begin
        pred_hit    <= c_hit;
        pred_target <= c_hit ? c_tgt : '0;
        pred_taken  <= (dyn_en && c_hit) ? h_ctr[1] : lk_disp_neg;
      end
      if (lk_valid)       pred_pending <= 1'b1;
      else if (upd_valid) pred_pending <= 1'b0;
    end
  end

  // R2: a result follows each lookup by one cycle
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_valid);
  assert_valid_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !pred_valid);
  // R5: static mode follows the displacement sign
  assert_static_R5: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && !dyn_en) |=> pred_taken == $past(lk_disp_neg));
  // R3: a miss reports a zero target
  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && !pred_hit) |-> pred_target == '0);
  // R10: pending flag tracks lookups and resolutions
  assert_pending_set_R10: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> pred_pending);
  assert_pending_clr_R10: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !lk_valid) |=> !pred_pending);
endmodule

// File: tb/sim_bpred_top.sv
module sim_bpred_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_disp_neg = 1'b0, dyn_en = 1'b1;
  logic [31:0] lk_pc = '0, upd_pc = '0, upd_target = '0;
  logic        upd_valid = 1'b0, upd_taken = 1'b0;
  logic        pred_valid, pred_hit, pred_taken, pred_pending;
  logic [31:0] pred_target;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bpred_top u0 (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_pc(lk_pc), .lk_disp_neg(lk_disp_neg),
    .dyn_en(dyn_en), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .pred_valid(pred_valid), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_target(pred_target), .pred_pending(pred_pending)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // one cycle of stimulus starting just after a falling edge; returns after next falling edge
  task automatic cycle(input logic lk, input logic [31:0] lpc, input logic neg, input logic dyn,
                       input logic up, input logic [31:0] upc, input logic tk, input logic [31:0] tgt);
    lk_valid = lk; lk_pc = lpc; lk_disp_neg = neg; dyn_en = dyn;
    upd_valid = up; upd_pc = upc; upd_taken = tk; upd_target = tgt;
    @(posedge clk);
    #1 lk_valid = 1'b0; upd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic look(input logic [31:0] pc, input logic neg, input logic dyn);
    cycle(1'b1, pc, neg, dyn, 1'b0, '0, 1'b0, '0);
  endtask

  task automatic upd(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
    cycle(1'b0, '0, 1'b0, 1'b1, 1'b1, pc, tk, tgt);
  endtask

  function automatic logic [31:0] pc_of(input logic [23:0] tag, input logic [3:0] set);
    return {tag, set, 4'h0};
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog act=1 exp=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pa, pb;
    int ctr;
    logic pat [12] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 valid", pred_valid, 0);
    check("R1 hit", pred_hit, 0);
    check("R1 taken", pred_taken, 0);
    check("R1 pending", pred_pending, 0);

    // R5 / R3: cold misses follow the displacement sign in both modes
    pa = pc_of(24'h000012, 4'h3);
    for (int m = 0; m < 4; m++) begin
      look(pa, m[0], m[1]);
      check("R2 valid", pred_valid, 1);
      check("R3 cold miss", pred_hit, 0);
      check("R3 miss target", pred_target, 0);
      check("R5 static on miss", pred_taken, m[0]);
      check("R10 pending set", pred_pending, 1);
    end
    @(negedge clk);
    check("R2 single cycle", pred_valid, 0);

    // R6 / R4: counter training sweep, model starts weakly not-taken (R1)
    ctr = 1;
    for (int i = 0; i < 12; i++) begin
      upd(pa, pat[i], 32'h0000_8000);
      check("R10 pending cleared", pred_pending, 0);
      ctr = pat[i] ? (ctr < 3 ? ctr + 1 : 3) : (ctr > 0 ? ctr - 1 : 0);
      look(pa, 1'b0, 1'b1);
      check("R3 trained hit", pred_hit, 1);
      check("R3 target", pred_target, 32'h0000_8000);
      check("R6 R4 dynamic taken", pred_taken, (ctr >= 2) ? 1 : 0);
      // R5: static mode on a hit uses the sign, both polarities
      look(pa, 1'b1, 1'b0);
      check("R5 static backward", pred_taken, 1);
      look(pa, 1'b0, 1'b0);
      check("R5 static forward", pred_taken, 0);
    end

    // R9: lookup and taken update in the same cycle
    pb = pc_of(24'h000045, 4'h6);
    cycle(1'b1, pb, 1'b0, 1'b1, 1'b1, pb, 1'b1, 32'h0000_9000);
    check("R9 same cycle not seen", pred_hit, 0);
    check("R9 same cycle taken", pred_taken, 0);
    check("R10 lookup wins", pred_pending, 1);
    look(pb, 1'b0, 1'b1);
    check("R9 next hit", pred_hit, 1);
    check("R9 next taken", pred_taken, 1);
    check("R9 next target", pred_target, 32'h0000_9000);

    // R7: not-taken update to a new address does not fill
    upd(pc_of(24'h000077, 4'h6), 1'b0, 32'h1);
    look(pc_of(24'h000077, 4'h6), 1'b0, 1'b1);
    check("R7 not-taken no fill", pred_hit, 0);

    // R7 / R8: overfill set 5; fills go to ways 0..3, then the victim is way 0
    for (int k = 0; k < 5; k++) upd(pc_of(24'h100 + 24'(k), 4'h5), 1'b1, 32'hA000_0000 + 32'(k));
    look(pc_of(24'h100, 4'h5), 1'b0, 1'b1);
    check("R8 first victim way0", pred_hit, 0);
    for (int k = 1; k < 5; k++) begin
      look(pc_of(24'h100 + 24'(k), 4'h5), 1'b0, 1'b1);
      check("R7 survivor hit", pred_hit, 1);
      check("R7 survivor target", pred_target, 32'hA000_0000 + 32'(k));
    end
    // R7: hit overwrite of way1 target, which also touches way1 so the victim becomes way2
    upd(pc_of(24'h101, 4'h5), 1'b1, 32'hB000_0001);
    look(pc_of(24'h101, 4'h5), 1'b0, 1'b1);
    check("R7 overwrite target", pred_target, 32'hB000_0001);
    upd(pc_of(24'h105, 4'h5), 1'b1, 32'hA000_0005);
    look(pc_of(24'h102, 4'h5), 1'b0, 1'b1);
    check("R8 second victim way2", pred_hit, 0);
    look(pc_of(24'h103, 4'h5), 1'b0, 1'b1);
    check("R8 way3 kept", pred_hit, 1);
    look(pc_of(24'h105, 4'h5), 1'b0, 1'b1);
    check("R8 new entry hit", pred_hit, 1);
    check("R8 new entry target", pred_target, 32'hA000_0005);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule